// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Fixed-Margin Threshold Flags

This block buffers 8-bit words between two unrelated clock domains. A producer pushes bytes on its own clock; a consumer pops them on a second clock into a registered output. Both sides see status flags that are active low and registered in their own domain. The writer sees full and almost-full. The reader sees empty and almost-empty. The two threshold flags trip at a fixed margin of seven words from either end.

Each side keeps a binary pointer one bit wider than the storage address, together with a Gray-coded copy of it. The Gray copy passes through a two-stage synchronizer into the other domain. There it is converted back to binary and compared with the local pointer. A flag computed this way can only be pessimistic. The writer may see a stale read pointer, so it may report "fuller" than the truth. The reader may see a stale write pointer, so it may report "emptier". Neither side can therefore overflow or underflow. The depth is a parameter and may be any power of two from 64 to 4096.

Top module: `afifo_byte_top`

## Requirements
- R1: While either reset is high, and after reset, wr_full_n=1, wr_afull_n=1, rd_empty_n=0, rd_aempty_n=0 and rd_data=0.
- R2: Words leave in the order they were accepted, with no loss or duplication, including across pointer wrap-around.
- R3: wr_full_n is 0 exactly when DEPTH words are stored; a write attempted while wr_full_n=0 is discarded and does not change the stored contents.
- R4: wr_afull_n is 0 when the stored count is at least DEPTH-7 and 1 when it is below DEPTH-7 (after cross-domain settling).
- R5: rd_empty_n is 0 when no word is stored; a read attempted while rd_empty_n=0 is discarded and the output register keeps its last value.
- R6: rd_aempty_n is 0 when the stored count is 7 or fewer and 1 when it is 8 or more (after cross-domain settling).
- R7: After a write into an empty FIFO, rd_empty_n rises on the second to fourth rising read-clock edge following the write edge.
- R8: rd_oe only gates the output: rd_data reads 0 while rd_oe=0, and the held word reappears unchanged when rd_oe returns to 1.
- R9: A read with rd_en=1 while rd_empty_n=1 loads the oldest word into the output register on that rising read-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| wr_full_n | output | 1 | Low when all entries are occupied |
| wr_afull_n | output | 1 | Low when at most seven free entries remain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_oe | input | 1 | Output gate; 0 forces rd_data to zero |
| rd_data | output | 8 | Output register contents, gated by rd_oe |
| rd_empty_n | output | 1 | Low when no entry is occupied |
| rd_aempty_n | output | 1 | Low when seven or fewer entries are occupied |

## Verification
On every cycle, the assertions check that a pointer cannot advance while its guarding flag is active. They also check that the Gray-coded pointers never change more than one bit per clock. The output register must hold while the FIFO is empty, and each main flag must imply its threshold flag. The following can only be shown by the bench's scenarios: the exact counts where the threshold flags trip, the data ordering across wrap-around, the first-word latency through the synchronizers, and the output gating.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_MAXW = 13;  // enough for a 4096-entry pointer plus wrap bit
    localparam int EDGE_GAP = 7;   // threshold-flag margin in words

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rd_flags_t;

    function automatic logic [PTR_MAXW-1:0] bin2gray(input logic [PTR_MAXW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAXW-1:0] gray2bin(input logic [PTR_MAXW-1:0] g);
        logic [PTR_MAXW-1:0] b;
        b[PTR_MAXW-1] = g[PTR_MAXW-1];
        for (int i = PTR_MAXW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_gray_sync.sv
module afifo_gray_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MARGIN = EDGE_GAP,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [PW-1:0] rgray_s,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output wr_flags_t     flags
);
    logic [PW-1:0] wbin, wbin_nx, rbin, used_nx;

    assign push    = wen && flags.full_n;
    assign wbin_nx = wbin + PW'(push);
    assign rbin    = PW'(gray2bin(PTR_MAXW'(rgray_s)));
    assign used_nx = wbin_nx - rbin;
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin          <= '0;
            wgray         <= '0;
            flags.full_n  <= 1'b1;
            flags.afull_n <= 1'b1;
        end else begin
            wbin          <= wbin_nx;
            wgray         <= PW'(bin2gray(PTR_MAXW'(wbin_nx)));
            flags.full_n  <= (used_nx != PW'(DEPTH));
            flags.afull_n <= (used_nx <  PW'(DEPTH - MARGIN));
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |=> $stable(wbin));
    a_r4_full_implies_afull: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.afull_n);
    a_r2_wgray_one_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MARGIN = EDGE_GAP,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren,
    input  logic [PW-1:0] wgray_s,
    output logic          pop,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output rd_flags_t     flags
);
    logic [PW-1:0] rbin, rbin_nx, wbin, avail_nx;

    assign pop      = ren && flags.empty_n;
    assign rbin_nx  = rbin + PW'(pop);
    assign wbin     = PW'(gray2bin(PTR_MAXW'(wgray_s)));
    assign avail_nx = wbin - rbin_nx;
    assign raddr    = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin           <= '0;
            rgray          <= '0;
            flags.empty_n  <= 1'b0;
            flags.aempty_n <= 1'b0;
        end else begin
            rbin           <= rbin_nx;
            rgray          <= PW'(bin2gray(PTR_MAXW'(rbin_nx)));
            flags.empty_n  <= (avail_nx != '0);
            flags.aempty_n <= (avail_nx >  PW'(MARGIN));
        end
    end

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |=> $stable(rbin));
    a_r6_empty_implies_aempty: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |-> !flags.aempty_n);
    a_r2_rgray_one_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  q
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    q <= '0;
        else if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/afifo_byte_top.sv
module afifo_byte_top
    import afifo_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SYNC_FF = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_full_n,
    output logic              wr_afull_n,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              rd_oe,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_empty_n,
    output logic              rd_aempty_n
);
    logic          push, pop;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    wr_flags_t     wfl;
    rd_flags_t     rfl;
    logic [BYTE_W-1:0] dq;

    afifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wen(wr_en), .rgray_s(rgray_s),
        .push(push), .waddr(waddr), .wgray(wgray), .flags(wfl)
    );

    afifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .ren(rd_en), .wgray_s(wgray_s),
        .pop(pop), .raddr(raddr), .rgray(rgray), .flags(rfl)
    );

    afifo_gray_sync #(.W(PW), .STAGES(SYNC_FF)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );

    afifo_gray_sync #(.W(PW), .STAGES(SYNC_FF)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );

    afifo_ram #(.DEPTH(DEPTH), .W(BYTE_W)) u_ram (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(pop), .raddr(raddr), .q(dq)
    );

    assign wr_full_n   = wfl.full_n;
    assign wr_afull_n  = wfl.afull_n;
    assign rd_empty_n  = rfl.empty_n;
    assign rd_aempty_n = rfl.aempty_n;
    assign rd_data     = rd_oe ? dq : '0;

    a_r5_hold_output: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_empty_n |=> $stable(dq));
endmodule

// File: tb/tb_afifo_byte_top.sv
module tb_afifo_byte_top;
    localparam int DEPTH = 64;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1;
    logic wr_en = 0, rd_en = 0, rd_oe = 1;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic wr_full_n, wr_afull_n, rd_empty_n, rd_aempty_n;

    always #10 wr_clk = ~wr_clk;
    initial begin
        #5;
        forever #10 rd_clk = ~rd_clk;
    end

    afifo_byte_top #(.DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full_n(wr_full_n), .wr_afull_n(wr_afull_n),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_oe(rd_oe),
        .rd_data(rd_data), .rd_empty_n(rd_empty_n), .rd_aempty_n(rd_aempty_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // model
    logic [7:0] mq [DEPTH];
    int head = 0, tail = 0, cnt = 0;
    logic [7:0] seq = 8'h10;
    logic [7:0] last_out = 8'h00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write();
        @(negedge wr_clk);
        wr_en = 1; wr_data = seq;
        @(negedge wr_clk);
        wr_en = 0;
        if (cnt < DEPTH) begin
            mq[tail] = seq; tail = (tail + 1) % DEPTH; cnt++;
        end
        seq = seq + 8'd1;
    endtask

    task automatic do_read();
        @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        if (cnt > 0) begin
            last_out = mq[head]; head = (head + 1) % DEPTH; cnt--;
            chk("R2/R9 data", {24'd0, rd_data}, {24'd0, last_out});
        end else begin
            chk("R5 hold on empty read", {24'd0, rd_data}, {24'd0, last_out});
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic chk_flags(input string tag, input logic [3:0] exp);
        chk({tag, " R3 full_n"},   {31'd0, wr_full_n},   {31'd0, exp[3]});
        chk({tag, " R4 afull_n"},  {31'd0, wr_afull_n},  {31'd0, exp[2]});
        chk({tag, " R5 empty_n"},  {31'd0, rd_empty_n},  {31'd0, exp[1]});
        chk({tag, " R6 aempty_n"}, {31'd0, rd_aempty_n}, {31'd0, exp[0]});
    endtask

    // {writes, reads, full_n, afull_n, empty_n, aempty_n}
    localparam logic [19:0] VEC [9] = '{
        {8'd1,  8'd0,  4'b1110},  // 1 stored
        {8'd6,  8'd0,  4'b1110},  // 7: still almost empty
        {8'd1,  8'd0,  4'b1111},  // 8: leaves almost empty
        {8'd49, 8'd0,  4'b1011},  // 57 = DEPTH-7: almost full
        {8'd0,  8'd1,  4'b1111},  // 56: releases almost full
        {8'd8,  8'd0,  4'b0011},  // 64: full
        {8'd3,  8'd0,  4'b0011},  // ignored while full
        {8'd0,  8'd64, 4'b1100},  // drain to empty
        {8'd0,  8'd2,  4'b1100}   // ignored while empty
    };

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        // R1: flags while in reset
        chk_flags("R1 in-reset", 4'b1100);
        wr_rst = 0; rd_rst = 0;
        settle();
        chk_flags("R1 after-reset", 4'b1100);
        chk("R1 rd_data", {24'd0, rd_data}, 32'd0);

        for (int i = 0; i < 9; i++) begin
            for (int w = 0; w < int'(VEC[i][19:12]); w++) do_write();
            for (int r = 0; r < int'(VEC[i][11:4]); r++) do_read();
            settle();
            chk_flags($sformatf("vec%0d", i), VEC[i][3:0]);
        end

        // R7: first-word latency from empty
        begin
            int n;
            n = 0;
            do_write();
            while (!rd_empty_n && n < 10) begin
                @(posedge rd_clk); #1; n++;
            end
            checks++;
            if (n < 2 || n > 4) begin
                errors++;
                $display("FAIL R7 latency actual=%0d expected=2..4", n);
            end
        end
        do_read();  // R9: loads the word
        settle();
        chk("R5 empty after single read", {31'd0, rd_empty_n}, 32'd0);

        // R8: output gating
        rd_oe = 0; #1;
        chk("R8 gated zero", {24'd0, rd_data}, 32'd0);
        repeat (3) @(negedge rd_clk);
        rd_oe = 1; #1;
        chk("R8 value restored", {24'd0, rd_data}, {24'd0, last_out});

        // R1: reset mid-run
        for (int w = 0; w < 10; w++) do_write();
        settle();
        chk_flags("pre-reset", 4'b1111);
        wr_rst = 1; rd_rst = 1;
        repeat (4) @(negedge rd_clk);
        wr_rst = 0; rd_rst = 0;
        head = 0; tail = 0; cnt = 0; last_out = 0;
        settle();
        chk_flags("R1 mid-run reset", 4'b1100);
        chk("R1 rd_data after reset", {24'd0, rd_data}, 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule